// File: doc/BRIEF.md
# Segment-Based Address Translator

This block maps a logical address onto a physical address through a small segment table held in flip-flops. The upper bits of the logical address pick a segment and the lower bits give an offset into it. Each segment entry stores a base address, a limit, a residency flag and a dirty flag. A length register says how many segments, counted from segment zero, are live. A lookup adds the zero-extended offset to the segment's base. It also checks the segment number against the length, the residency flag and the limit. The block answers with either a physical address or a fault code.

Requests arrive on a valid/ready channel. The translator takes a request on any clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low only while reset is asserted, so the requester sees no back-pressure in normal operation. It must hold `req_addr` and `req_write` stable while it waits for ready. The answer comes back as a one-cycle `rsp_valid` pulse, and the response side cannot stall. A separate load port writes entries and the length register. A lookup always sees the table as it stood before the edge that accepts it.

Top module: `seg_xlate`

## Requirements
- R1: The segment number is `req_addr[15:12]` and the offset is `req_addr[11:0]`. On success `rsp_paddr` equals the segment base plus the zero-extended offset, taken modulo 2^16. This is an addition, not a concatenation.
- R2: A segment number greater than or equal to the length register gives fault code 1.
- R3: A segment within the length whose residency flag is clear gives fault code 2.
- R4: An offset greater than or equal to the segment's limit gives fault code 3. A limit of 0 refuses every offset. On any fault, `rsp_paddr` and `rsp_dirty` read 0.
- R5: Faults are ranked in the order code 1, then code 2, then code 3, and only the highest-ranked code is reported. Code 0 means success.
- R6: A request accepted on an edge produces exactly one `rsp_valid` pulse, which appears after that same edge. A cycle without an accepted request gives no response. Back-to-back requests get back-to-back responses.
- R7: A write access (`req_write`=1) that succeeds sets the dirty flag of its segment. On success, `rsp_dirty` reports the flag including this access. Reads and faulted writes leave the flag unchanged.
- R8: An entry or length load on the same edge as a lookup affects only later lookups. Loading an entry clears its dirty flag.
- R9: Synchronous reset clears every residency flag, every dirty flag, the length register and `rsp_valid`, and holds `req_ready` low. The first lookup after reset therefore faults with code 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Translator can accept a request |
| req_addr | input | 16 | Logical address: segment number over offset |
| req_write | input | 1 | Request is a write access |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 16 | Translated physical address, 0 on fault |
| rsp_fault | output | 2 | 0 ok, 1 beyond length, 2 not resident, 3 beyond limit |
| rsp_dirty | output | 1 | Dirty flag of the segment after this access |
| ld_entry_we | input | 1 | Load one table entry |
| ld_idx | input | 4 | Entry to load |
| ld_base | input | 16 | Base address to store |
| ld_limit | input | 13 | Limit to store (0 to 4096) |
| ld_present | input | 1 | Residency flag to store |
| ld_len_we | input | 1 | Load the length register |
| ld_len | input | 5 | Number of live segments (0 to 16) |

## Verification
Each result is due on the clock edge that follows the edge accepting its request, whether it is an address, a fault code or a dirty flag. The bench drives inputs on the falling edge and samples the response on the next falling edge. By then exactly one rising edge has passed through the single output register. Dirty flags and table or length loads become visible one edge after their cause. Each check therefore issues the probing lookup on the cycle after the load and reads its answer one cycle later still. The same-cycle collision cases sample the response to the colliding lookup, which should show the old contents, and then probe once more for the new contents.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_RANGE  = 2'd1,
    FLT_ABSENT = 2'd2,
    FLT_LIMIT  = 2'd3
  } fault_e;
endpackage

// File: rtl/seg_xlate_table.sv
module seg_xlate_table #(
  parameter int SEG_W = 4,
  parameter int LIM_W = 13,
  parameter int PA_W  = 16,
  localparam int NSEG  = 1 << SEG_W,
  localparam int LEN_W = SEG_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_en,
  input  logic [SEG_W-1:0] ld_idx,
  input  logic [PA_W-1:0]  ld_base,
  input  logic [LIM_W-1:0] ld_limit,
  input  logic             ld_present,
  input  logic             len_en,
  input  logic [LEN_W-1:0] len_val,
  input  logic             mark_en,
  input  logic [SEG_W-1:0] mark_idx,
  input  logic [SEG_W-1:0] rd_idx,
  output logic [PA_W-1:0]  rd_base,
  output logic [LIM_W-1:0] rd_limit,
  output logic             rd_present,
  output logic             rd_modified,
  output logic [LEN_W-1:0] tbl_len
);
  logic [PA_W-1:0]  base_q  [NSEG];
  logic [LIM_W-1:0] limit_q [NSEG];
  logic [NSEG-1:0]  pres_q;
  logic [NSEG-1:0]  mod_q;
  logic [LEN_W-1:0] len_q;

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    logic hit_ld, hit_mark;
    assign hit_ld   = ld_en && (ld_idx == SEG_W'(g));
    assign hit_mark = mark_en && (mark_idx == SEG_W'(g));

    always_ff @(posedge clk) begin
      if (hit_ld) begin
        base_q[g]  <= ld_base;
        limit_q[g] <= ld_limit;
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        pres_q[g] <= 1'b0;
        mod_q[g]  <= 1'b0;
      end else if (hit_ld) begin
        pres_q[g] <= ld_present;
        mod_q[g]  <= 1'b0;
      end else if (hit_mark) begin
        mod_q[g]  <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         len_q <= '0;
    else if (len_en) len_q <= len_val;
  end

  assign rd_base     = base_q[rd_idx];
  assign rd_limit    = limit_q[rd_idx];
  assign rd_present  = pres_q[rd_idx];
  assign rd_modified = mod_q[rd_idx];
  assign tbl_len     = len_q;
endmodule

// File: rtl/seg_xlate_check.sv
module seg_xlate_check
  import seg_xlate_pkg::*;
#(
  parameter int SEG_W = 4,
  parameter int OFF_W = 12,
  parameter int PA_W  = 16,
  localparam int LIM_W = OFF_W + 1,
  localparam int LEN_W = SEG_W + 1
) (
  input  logic [SEG_W-1:0] seg,
  input  logic [OFF_W-1:0] off,
  input  logic             is_write,
  input  logic [LEN_W-1:0] tbl_len,
  input  logic [PA_W-1:0]  base,
  input  logic [LIM_W-1:0] limit,
  input  logic             present,
  input  logic             modified,
  output fault_e           fault,
  output logic [PA_W-1:0]  paddr,
  output logic             dirty,
  output logic             mark
);
  logic beyond_len, beyond_lim;

  assign beyond_len = {1'b0, seg} >= tbl_len;
  assign beyond_lim = {1'b0, off} >= limit;

  always_comb begin
    if (beyond_len)      fault = FLT_RANGE;
    else if (!present)   fault = FLT_ABSENT;
    else if (beyond_lim) fault = FLT_LIMIT;
    else                 fault = FLT_NONE;
  end

  always_comb begin
    mark  = 1'b0;
    paddr = '0;
    dirty = 1'b0;
    if (fault == FLT_NONE) begin
      paddr = base + PA_W'(off);
      mark  = is_write;
      dirty = modified | is_write;
    end
  end
endmodule

// File: rtl/seg_xlate_resp.sv
module seg_xlate_resp
  import seg_xlate_pkg::*;
#(
  parameter int PA_W = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            fire,
  input  fault_e          fault_d,
  input  logic [PA_W-1:0] paddr_d,
  input  logic            dirty_d,
  output logic            rsp_valid,
  output logic [PA_W-1:0] rsp_paddr,
  output logic [1:0]      rsp_fault,
  output logic            rsp_dirty
);
  always_ff @(posedge clk) begin
    if (rst) rsp_valid <= 1'b0;
    else     rsp_valid <= fire;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_paddr <= '0;
      rsp_fault <= '0;
      rsp_dirty <= 1'b0;
    end else if (fire) begin
      rsp_paddr <= paddr_d;
      rsp_fault <= fault_d;
      rsp_dirty <= dirty_d;
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SEG_W  = 4,
  parameter int PA_W   = 16,
  localparam int OFF_W = ADDR_W - SEG_W,
  localparam int LIM_W = OFF_W + 1,
  localparam int LEN_W = SEG_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  output logic              rsp_valid,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic [1:0]        rsp_fault,
  output logic              rsp_dirty,
  input  logic              ld_entry_we,
  input  logic [SEG_W-1:0]  ld_idx,
  input  logic [PA_W-1:0]   ld_base,
  input  logic [LIM_W-1:0]  ld_limit,
  input  logic              ld_present,
  input  logic              ld_len_we,
  input  logic [LEN_W-1:0]  ld_len
);
  logic             fire;
  logic [SEG_W-1:0] seg;
  logic [OFF_W-1:0] off;
  logic [PA_W-1:0]  e_base;
  logic [LIM_W-1:0] e_limit;
  logic             e_present, e_modified;
  logic [LEN_W-1:0] tbl_len;
  fault_e           fault_d;
  logic [PA_W-1:0]  paddr_d;
  logic             dirty_d, mark_d;

  assign req_ready = ~rst;
  assign fire      = req_valid & req_ready;
  assign seg       = req_addr[ADDR_W-1 -: SEG_W];
  assign off       = req_addr[OFF_W-1:0];

  seg_xlate_table #(.SEG_W(SEG_W), .LIM_W(LIM_W), .PA_W(PA_W)) u_table (
    .clk(clk), .rst(rst),
    .ld_en(ld_entry_we), .ld_idx(ld_idx), .ld_base(ld_base),
    .ld_limit(ld_limit), .ld_present(ld_present),
    .len_en(ld_len_we), .len_val(ld_len),
    .mark_en(fire & mark_d), .mark_idx(seg),
    .rd_idx(seg), .rd_base(e_base), .rd_limit(e_limit),
    .rd_present(e_present), .rd_modified(e_modified), .tbl_len(tbl_len)
  );

  seg_xlate_check #(.SEG_W(SEG_W), .OFF_W(OFF_W), .PA_W(PA_W)) u_check (
    .seg(seg), .off(off), .is_write(req_write), .tbl_len(tbl_len),
    .base(e_base), .limit(e_limit), .present(e_present),
    .modified(e_modified), .fault(fault_d), .paddr(paddr_d),
    .dirty(dirty_d), .mark(mark_d)
  );

  seg_xlate_resp #(.PA_W(PA_W)) u_resp (
    .clk(clk), .rst(rst), .fire(fire), .fault_d(fault_d),
    .paddr_d(paddr_d), .dirty_d(dirty_d), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_dirty(rsp_dirty)
  );
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int ADDR_W = 16,
  parameter int SEG_W  = 4,
  parameter int PA_W   = 16,
  localparam int OFF_W = ADDR_W - SEG_W,
  localparam int LIM_W = OFF_W + 1,
  localparam int LEN_W = SEG_W + 1,
  localparam int NSEG  = 1 << SEG_W
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [PA_W-1:0]   rsp_paddr,
  input logic [1:0]        rsp_fault,
  input logic              rsp_dirty,
  input logic              ld_entry_we,
  input logic [SEG_W-1:0]  ld_idx,
  input logic              ld_present,
  input logic              ld_len_we,
  input logic [LEN_W-1:0]  ld_len
);
  logic             fire, rst_d;
  logic [SEG_W-1:0] seg;
  logic [LEN_W-1:0] len_sh;
  logic [NSEG-1:0]  pres_sh;

  assign fire = req_valid && req_ready;
  assign seg  = req_addr[ADDR_W-1 -: SEG_W];

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) begin
      len_sh  <= '0;
      pres_sh <= '0;
    end else begin
      if (ld_len_we)   len_sh <= ld_len;
      if (ld_entry_we) pres_sh[ld_idx] <= ld_present;
    end
  end

  assert_rsp_follows_fire_R6: assert property (@(posedge clk) disable iff (rst)
    fire |=> rsp_valid);
  assert_idle_no_rsp_R6: assert property (@(posedge clk) disable iff (rst)
    !fire |=> !rsp_valid);
  assert_range_fault_R2: assert property (@(posedge clk) disable iff (rst)
    (fire && ({1'b0, seg} >= len_sh)) |=> (rsp_fault == 2'd1));
  assert_absent_fault_R3: assert property (@(posedge clk) disable iff (rst)
    (fire && ({1'b0, seg} < len_sh) && !pres_sh[seg]) |=> (rsp_fault == 2'd2));
  assert_fault_zeroes_R4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0 && !rsp_dirty));
  assert_quiet_after_reset_R9: assert property (@(posedge clk) disable iff (rst)
    rst_d |-> !rsp_valid);
endmodule

bind seg_xlate seg_xlate_chk #(.ADDR_W(ADDR_W), .SEG_W(SEG_W), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
  .rsp_fault(rsp_fault), .rsp_dirty(rsp_dirty), .ld_entry_we(ld_entry_we),
  .ld_idx(ld_idx), .ld_present(ld_present), .ld_len_we(ld_len_we),
  .ld_len(ld_len)
);

// File: tb/seg_xlate_bench.sv
module seg_xlate_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_ready, rsp_valid, rsp_dirty;
  logic [15:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        ld_entry_we = 1'b0, ld_present = 1'b0, ld_len_we = 1'b0;
  logic [3:0]  ld_idx = '0;
  logic [15:0] ld_base = '0;
  logic [12:0] ld_limit = '0;
  logic [4:0]  ld_len = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  seg_xlate u_seg_xlate (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .rsp_valid(rsp_valid),
    .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_dirty(rsp_dirty),
    .ld_entry_we(ld_entry_we), .ld_idx(ld_idx), .ld_base(ld_base),
    .ld_limit(ld_limit), .ld_present(ld_present), .ld_len_we(ld_len_we),
    .ld_len(ld_len)
  );

  // vector: {write, addr, fault, paddr, dirty}
  localparam int NV = 16;
  localparam logic [35:0] VEC [NV] = '{
    {1'b0, 16'h0000, 2'd0, 16'h1000, 1'b0},  // R1 base + 0
    {1'b0, 16'h07FF, 2'd0, 16'h17FF, 1'b0},  // R1 last offset below limit
    {1'b0, 16'h0800, 2'd3, 16'h0000, 1'b0},  // R4 offset equals limit
    {1'b0, 16'h1FFF, 2'd0, 16'h07FF, 1'b0},  // R1 sum wraps
    {1'b0, 16'h1123, 2'd0, 16'hF923, 1'b0},  // R1 add with carries
    {1'b0, 16'h2005, 2'd2, 16'h0000, 1'b0},  // R3 not resident
    {1'b0, 16'h2FFF, 2'd2, 16'h0000, 1'b0},  // R5 code 2 over code 3
    {1'b0, 16'h3000, 2'd1, 16'h0000, 1'b0},  // R5 code 1 over valid entry
    {1'b0, 16'hF000, 2'd1, 16'h0000, 1'b0},  // R2 top segment
    {1'b1, 16'h0900, 2'd3, 16'h0000, 1'b0},  // R7 faulted write
    {1'b0, 16'h0010, 2'd0, 16'h1010, 1'b0},  // R7 flag still clear
    {1'b1, 16'h0010, 2'd0, 16'h1010, 1'b1},  // R7 write sets flag
    {1'b0, 16'h0004, 2'd0, 16'h1004, 1'b1},  // R7 flag persists
    {1'b0, 16'h1000, 2'd0, 16'hF800, 1'b0},  // R7 other segment clean
    {1'b1, 16'h2000, 2'd2, 16'h0000, 1'b0},  // R3 write to absent
    {1'b1, 16'h3001, 2'd1, 16'h0000, 1'b0}   // R2 write beyond length
  };

  task automatic chk(string tag, logic [18:0] got, logic [18:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // compare {valid, fault, paddr} and dirty
  task automatic chk_rsp(string tag, logic [1:0] f, logic [15:0] pa, logic d);
    chk(tag, {rsp_valid, rsp_fault, rsp_paddr}, {1'b1, f, pa});
    chk({tag, " dirty"}, {18'd0, rsp_dirty}, {18'd0, d});
  endtask

  task automatic load(logic [3:0] i, logic [15:0] b, logic [12:0] l, logic p);
    ld_entry_we = 1'b1; ld_idx = i; ld_base = b; ld_limit = l; ld_present = p;
    @(negedge clk);
    ld_entry_we = 1'b0;
  endtask

  task automatic lookup(logic w, logic [15:0] a);
    req_valid = 1'b1; req_write = w; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 ready low in reset", {18'd0, req_ready}, 19'd0);
    chk("R9 no response in reset", {18'd0, rsp_valid}, 19'd0);
    rst = 1'b0;
    lookup(1'b0, 16'h0000);
    chk_rsp("R9 length zero after reset", 2'd1, 16'h0000, 1'b0);

    load(4'd0, 16'h1000, 13'h0800, 1'b1);
    load(4'd1, 16'hF800, 13'h1000, 1'b1);
    load(4'd2, 16'h4000, 13'h0100, 1'b0);
    load(4'd3, 16'h2000, 13'h0010, 1'b1);
    ld_len_we = 1'b1; ld_len = 5'd3;
    @(negedge clk);
    ld_len_we = 1'b0;

    for (int i = 0; i < NV; i++) begin
      req_valid = 1'b1; req_write = VEC[i][35]; req_addr = VEC[i][34:19];
      @(negedge clk);
      chk_rsp($sformatf("vector %0d R1-table", i), VEC[i][18:17], VEC[i][16:1], VEC[i][0]);
    end
    req_valid = 1'b0; req_write = 1'b0;
    @(negedge clk);
    chk("R6 idle cycle gives no response", {18'd0, rsp_valid}, 19'd0);

    // R8: entry load collides with lookup of the same entry
    ld_entry_we = 1'b1; ld_idx = 4'd0; ld_base = 16'h5000; ld_limit = 13'h0800; ld_present = 1'b1;
    lookup(1'b0, 16'h0001);
    ld_entry_we = 1'b0;
    chk_rsp("R8 colliding lookup sees old entry", 2'd0, 16'h1001, 1'b1);
    lookup(1'b0, 16'h0001);
    chk_rsp("R8 new entry with clean flag", 2'd0, 16'h5001, 1'b0);

    // R8: length load collides with lookup
    ld_len_we = 1'b1; ld_len = 5'd4;
    lookup(1'b0, 16'h3000);
    ld_len_we = 1'b0;
    chk_rsp("R8 colliding lookup sees old length", 2'd1, 16'h0000, 1'b0);
    lookup(1'b0, 16'h3000);
    chk_rsp("R8 new length applies", 2'd0, 16'h2000, 1'b0);

    // R4: zero limit refuses offset zero
    load(4'd3, 16'h2000, 13'h0000, 1'b1);
    lookup(1'b0, 16'h3000);
    chk_rsp("R4 zero limit", 2'd3, 16'h0000, 1'b0);

    // R9: reset mid-run clears residency and length
    rst = 1'b1;
    @(negedge clk);
    chk("R9 ready low in second reset", {18'd0, req_ready}, 19'd0);
    rst = 1'b0;
    ld_len_we = 1'b1; ld_len = 5'd4;
    @(negedge clk);
    ld_len_we = 1'b0;
    lookup(1'b0, 16'h0001);
    chk_rsp("R9 residency cleared by reset", 2'd2, 16'h0000, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule